// File: doc/BRIEF.md
# Prioritised Routine Sequencer and Bus Arbiter

This block runs short stored microroutines against a companion memory device. Up to six routines sit in a 64-entry instruction store, and each has its own start-address input. Each store entry holds a 16-bit word, the levels for three bus strobes (write, command and compare-enable), a flag that marks the entry as an internal instruction, and an end-of-routine flag. When a bus entry executes, the block drives a one-cycle bus transfer that carries the stored word and strobe levels.

Routines 0 and 1 belong to the frame-parsing engine. They are time critical: they start one cycle sooner because their first entry is held in a prefetch buffer, and nothing can interrupt them. The host requests routines 2 to 5. Among these, a lower-numbered routine preempts a higher-numbered one, and the preempted routine later restarts from its first entry. A host that wants the bus for its own cycles gets a grant only while no routine is running or waiting. An active-low busy interrupt tells the host that the bus belongs to a routine.

Top module: `rtn_seq_arb`

## Requirements
- R1: After reset, int_n is 1, host_gnt is 0, bus_e_n, bus_w_n, bus_cm_n and bus_ec_n are 1, and bus_dq is 0.
- R2: A store entry is {ld_ctl, ld_word}. ld_ctl[0], [1] and [2] are the write, command and compare-enable levels, ld_ctl[3]=1 marks an internal instruction, and ld_ctl[4]=1 marks the last entry. A bus entry produces one cycle with bus_e_n=0, the three strobe levels and bus_dq equal to the word. An internal entry produces no strobe.
- R3: A running routine issues its entries one per cycle in address order and stops after the entry whose last flag is set.
- R4: A request pulse sampled at clock edge k+1 gives the first strobe after edge k+4 for routines 2 to 5, and after edge k+3 for routines 0 and 1, whose pointer begins at start address plus one.
- R5: A request that arrives while routine 0 or 1 runs does not interrupt it. It starts once that routine has ended.
- R6: Among routines 2 to 5, a pending lower-numbered routine preempts a running higher-numbered one, and the preempted routine then reruns from its first entry. A higher-numbered request waits until the running routine ends.
- R7: When requests for routine 0 or 1 and for routines 2 to 5 are pending together, routine 0 or 1 is served first.
- R8: An internal entry whose word[15:12] is 1 is a wait-for-match. While match_n is 1 it loads the pointer with word[5:0] and issues nothing. While match_n is 0 execution moves on to the next entry.
- R9: host_gnt rises only when host_req is 1, no routine is running and none is pending. It stays high while host_req stays high, and routines wait until it falls.
- R10: While host_gnt and host_req are both 1, the next cycle shows bus_e_n=0 with host_w_n, host_cm_n, host_ec_n and host_dq on the bus.
- R11: int_n is 0 exactly while a routine owns the bus, and it falls only in a cycle after host_gnt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Store write enable |
| ld_addr | input | 6 | Store write address |
| ld_word | input | 16 | Entry data word |
| ld_ctl | input | 5 | Entry control bits {last, internal, ec, cm, w} |
| start_addr | input | 36 | Six 6-bit start addresses, routine r at [6r+5:6r] |
| fe_req | input | 2 | Start pulses for routines 0 and 1 |
| hs_req | input | 4 | Start pulses for routines 2 to 5 |
| match_n | input | 1 | Active-low match flag from the memory device |
| host_req | input | 1 | Host wants direct bus cycles |
| host_w_n | input | 1 | Host write level |
| host_cm_n | input | 1 | Host command level |
| host_ec_n | input | 1 | Host compare-enable level |
| host_dq | input | 16 | Host bus word |
| host_gnt | output | 1 | Host owns the bus |
| int_n | output | 1 | Active-low busy interrupt |
| bus_e_n | output | 1 | Bus cycle strobe |
| bus_w_n | output | 1 | Bus write level |
| bus_cm_n | output | 1 | Bus command level |
| bus_ec_n | output | 1 | Bus compare-enable level |
| bus_dq | output | 16 | Bus word |

## Verification
The hardest case to reach from the ports is a preemption that lands partway through a routine, followed by the restart of that routine from its first entry. The bench starts routine 3 and then issues the routine 2 request on an exact cycle, so that the preemption cuts routine 3 off after two of its six entries. The complete strobe log must then read: two routine 3 words, all of routine 2, and routine 3 again from its first word. A host cycle that is held while a routine request arrives is checked the same way, through the order in the log and the levels of int_n and host_gnt.

// File: rtl/rtn_seq_pkg.sv
package rtn_seq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ENT_W  = WORD_W + 5;
  localparam logic [3:0]  OP_WAIT = 4'h1;

  typedef struct packed {
    logic              last;
    logic              own;
    logic              ec_n;
    logic              cm_n;
    logic              w_n;
    logic [WORD_W-1:0] word;
  } rtn_ent_t;
endpackage

// File: rtl/rtn_store.sv
module rtn_store #(
  parameter int AW = 6,
  parameter int EW = 21
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtn_pick.sv
module rtn_pick #(
  parameter int NRT = 6,
  parameter int RW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NRT-1:0] req,
  input  logic [NRT-1:0] clr,
  input  logic [NRT-1:0] rearm,
  output logic [NRT-1:0] pend,
  output logic           pick_vld,
  output logic [RW-1:0]  pick_id
);
  for (genvar i = 0; i < NRT; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= ((pend[i] | req[i]) & ~clr[i]) | rearm[i];
    end
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_id  = '0;
    for (int i = NRT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_vld = 1'b1;
        pick_id  = RW'(i);
      end
    end
  end
endmodule

// File: rtl/rtn_pf.sv
module rtn_pf #(
  parameter int AW  = 6,
  parameter int NFE = 2,
  parameter int EW  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [NFE*AW-1:0] fe_sa,
  input  logic [EW-1:0]     rdata,
  output logic [AW-1:0]     raddr,
  output logic [NFE*EW-1:0] pf_flat
);
  localparam int SW = (NFE > 1) ? $clog2(NFE) : 1;

  logic [SW-1:0] sel_q, idx_q;
  logic          cap_q;

  assign raddr = fe_sa[int'(sel_q)*AW +: AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      idx_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_en;
      idx_q <= sel_q;
      if (cap_en) sel_q <= (int'(sel_q) == NFE - 1) ? '0 : sel_q + SW'(1);
    end
  end

  for (genvar i = 0; i < NFE; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) pf_flat[i*EW +: EW] <= '0;
      else if (cap_q && int'(idx_q) == i) pf_flat[i*EW +: EW] <= rdata;
    end
  end
endmodule

// File: rtl/rtn_seq_arb.sv
module rtn_seq_arb
  import rtn_seq_pkg::*;
#(
  parameter int AW  = 6,
  parameter int NRT = 6,
  parameter int NFE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [AW-1:0]      ld_addr,
  input  logic [WORD_W-1:0]  ld_word,
  input  logic [4:0]         ld_ctl,
  input  logic [NRT*AW-1:0]  start_addr,
  input  logic [NFE-1:0]     fe_req,
  input  logic [NRT-NFE-1:0] hs_req,
  input  logic               match_n,
  input  logic               host_req,
  input  logic               host_w_n,
  input  logic               host_cm_n,
  input  logic               host_ec_n,
  input  logic [WORD_W-1:0]  host_dq,
  output logic               host_gnt,
  output logic               int_n,
  output logic               bus_e_n,
  output logic               bus_w_n,
  output logic               bus_cm_n,
  output logic               bus_ec_n,
  output logic [WORD_W-1:0]  bus_dq
);
  localparam int RW = $clog2(NRT);
  localparam logic [RW-1:0] NFE_R = RW'(NFE);

  logic              run, xv, usepf, gnt_q;
  logic [RW-1:0]     cur;
  logic [AW-1:0]     ip, raddr, pf_raddr, pick_sa;
  logic [ENT_W-1:0]  rdata;
  logic [NFE*ENT_W-1:0] pf_flat;
  rtn_ent_t          ex;
  logic [NRT-1:0]    pend, clr, rearm;
  logic              pick_vld;
  logic [RW-1:0]     pick_id, pf_idx;
  logic              preempt, start_go, exec_go, is_wait, redirect, finish, exec_bus;

  rtn_store #(.AW(AW), .EW(ENT_W)) u_store (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata({ld_ctl, ld_word}),
    .raddr(raddr), .rdata(rdata)
  );

  rtn_pick #(.NRT(NRT), .RW(RW)) u_pick (
    .clk(clk), .rst(rst), .req({hs_req, fe_req}), .clr(clr), .rearm(rearm),
    .pend(pend), .pick_vld(pick_vld), .pick_id(pick_id)
  );

  rtn_pf #(.AW(AW), .NFE(NFE), .EW(ENT_W)) u_pf (
    .clk(clk), .rst(rst), .cap_en(!run), .fe_sa(start_addr[NFE*AW-1:0]),
    .rdata(rdata), .raddr(pf_raddr), .pf_flat(pf_flat)
  );

  assign raddr   = run ? ip : pf_raddr;
  assign pick_sa = start_addr[int'(pick_id)*AW +: AW];
  assign pf_idx  = (cur < NFE_R) ? cur : '0;

  always_comb begin
    if (usepf) ex = rtn_ent_t'(pf_flat[int'(pf_idx)*ENT_W +: ENT_W]);
    else       ex = rtn_ent_t'(rdata);
  end

  // lower number wins; only routines 2.. may be cut off
  assign preempt  = run && (cur >= NFE_R) && pick_vld && (pick_id < cur);
  assign start_go = pick_vld && !gnt_q && (!run || preempt);
  assign exec_go  = run && (usepf || xv) && !preempt;
  assign is_wait  = ex.own && (ex.word[WORD_W-1:WORD_W-4] == OP_WAIT);
  assign redirect = exec_go && is_wait && match_n;
  assign finish   = exec_go && ex.last && !redirect;
  assign exec_bus = exec_go && !ex.own;

  always_comb begin
    clr   = '0;
    rearm = '0;
    if (start_go) clr[pick_id] = 1'b1;
    if (start_go && preempt) rearm[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cur   <= '0;
      ip    <= '0;
      xv    <= 1'b0;
      usepf <= 1'b0;
    end else if (start_go) begin
      run   <= 1'b1;
      cur   <= pick_id;
      xv    <= 1'b0;
      usepf <= (pick_id < NFE_R);
      ip    <= (pick_id < NFE_R) ? pick_sa + AW'(1) : pick_sa;
    end else if (run) begin
      usepf <= 1'b0;
      if (finish) begin
        run <= 1'b0;
        xv  <= 1'b0;
      end else if (redirect) begin
        ip <= ex.word[AW-1:0];
        xv <= 1'b0;
      end else begin
        ip <= ip + AW'(1);
        xv <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= 1'b0;
    else     gnt_q <= host_req && (gnt_q || (!run && !pick_vld));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_e_n  <= 1'b1;
      bus_w_n  <= 1'b1;
      bus_cm_n <= 1'b1;
      bus_ec_n <= 1'b1;
      bus_dq   <= '0;
    end else if (exec_bus) begin
      bus_e_n  <= 1'b0;
      bus_w_n  <= ex.w_n;
      bus_cm_n <= ex.cm_n;
      bus_ec_n <= ex.ec_n;
      bus_dq   <= ex.word;
    end else if (gnt_q && host_req) begin
      bus_e_n  <= 1'b0;
      bus_w_n  <= host_w_n;
      bus_cm_n <= host_cm_n;
      bus_ec_n <= host_ec_n;
      bus_dq   <= host_dq;
    end else begin
      bus_e_n  <= 1'b1;
      bus_w_n  <= 1'b1;
      bus_cm_n <= 1'b1;
      bus_ec_n <= 1'b1;
      bus_dq   <= '0;
    end
  end

  assign host_gnt = gnt_q;
  assign int_n    = ~run;
endmodule

// File: rtl/rtn_seq_chk.sv
module rtn_seq_chk #(
  parameter int RW  = 3,
  parameter int NFE = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          int_n,
  input logic          host_gnt,
  input logic          host_req,
  input logic          bus_e_n,
  input logic          run,
  input logic [RW-1:0] cur
);
  AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(host_gnt && !int_n)); // R9
  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (rst) (host_gnt && host_req) |=> host_gnt); // R9
  AST_INT_AFTER_HOST: assert property (@(posedge clk) disable iff (rst) $fell(int_n) |-> !$past(host_gnt)); // R11
  AST_STROBE_OWNER: assert property (@(posedge clk) disable iff (rst) !bus_e_n |-> $past(!int_n || host_gnt)); // R10
  AST_FE_NOPREEMPT: assert property (@(posedge clk) disable iff (rst) (run && cur < RW'(NFE)) |=> (!run || cur == $past(cur))); // R5
  AST_PREEMPT_LOWER: assert property (@(posedge clk) disable iff (rst) (run && $past(run) && cur != $past(cur)) |-> cur < $past(cur)); // R6
endmodule

bind rtn_seq_arb rtn_seq_chk #(.RW(RW), .NFE(NFE)) u_chk (
  .clk(clk), .rst(rst), .int_n(int_n), .host_gnt(host_gnt), .host_req(host_req),
  .bus_e_n(bus_e_n), .run(run), .cur(cur)
);

// File: tb/sim_rtn_seq_arb.sv
module sim_rtn_seq_arb;
  logic        clk = 0, rst = 1;
  logic        ld_we = 0;
  logic [5:0]  ld_addr = 0;
  logic [15:0] ld_word = 0;
  logic [4:0]  ld_ctl = 0;
  logic [35:0] start_addr;
  logic [1:0]  fe_req = 0;
  logic [3:0]  hs_req = 0;
  logic        match_n = 0, host_req = 0, host_w_n = 1, host_cm_n = 1, host_ec_n = 1;
  logic [15:0] host_dq = 0;
  logic        host_gnt, int_n, bus_e_n, bus_w_n, bus_cm_n, bus_ec_n;
  logic [15:0] bus_dq;

  int tests = 0, fails = 0, cnt = 0, n = 0;
  logic [15:0] lw [256];
  logic [2:0]  lctl [256];
  int          lc [256];
  bit          done = 0;

  always #4 clk = ~clk;

  rtn_seq_arb u0 (.*);

  always @(posedge clk) cnt <= cnt + 1;

  always @(negedge clk) begin
    if (!rst && !bus_e_n && n < 256) begin
      lw[n]   <= bus_dq;
      lctl[n] <= {bus_ec_n, bus_cm_n, bus_w_n};
      lc[n]   <= cnt;
      n       <= n + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic clear_log;
    @(negedge clk); n = 0; #1;
  endtask

  task automatic put(int a, logic [15:0] w, logic [4:0] c);
    ld_we = 1; ld_addr = 6'(a); ld_word = w; ld_ctl = c; tick; ld_we = 0;
  endtask

  task automatic load_prog;
    int len [5] = '{3, 2, 4, 6, 3};
    for (int r = 0; r < 5; r++)
      for (int i = 0; i < len[r]; i++)
        put(r*8 + i, 16'hA000 | 16'(r << 8) | 16'(i),
            {(i == len[r]-1), 1'b0, 1'(i & 1), 1'b1, 1'b0});
    put(40, 16'hA500, 5'b00010);
    put(41, 16'h1029, 5'b01000);
    put(42, 16'hA502, 5'b10010);
  endtask

  task automatic t_reset;
    check(int_n == 1 && host_gnt == 0, "R1 int/gnt", {int_n, host_gnt}, 2'b10);
    check({bus_e_n, bus_w_n, bus_cm_n, bus_ec_n} == 4'hF && bus_dq == 0, "R1 bus idle", bus_dq, 0);
  endtask

  task automatic t_run_r2;
    int k;
    clear_log; k = cnt; hs_req = 4'b0001; tick; hs_req = 0;
    tick; check(int_n == 0, "R11 int low at start", int_n, 0);
    while (cnt < k + 6) tick;
    check(int_n == 0, "R11 int low while running", int_n, 0);
    tick; check(int_n == 1, "R3 int released after last", int_n, 1);
    repeat (4) tick;
    check(n == 4, "R3 entry count", n, 4);
    check(lc[0] == k + 4, "R4 latency routine 2", lc[0] - k, 4);
    for (int i = 0; i < 4; i++) check(lw[i] == (16'hA200 | 16'(i)), "R3 order r2", lw[i], 16'hA200 | i);
    check(lc[3] == k + 7, "R3 one per cycle", lc[3] - k, 7);
    check(lctl[0] == 3'b010 && lctl[1] == 3'b110, "R2 strobe levels", {lctl[0], lctl[1]}, 6'b010110);
  endtask

  task automatic t_run_r0;
    int k;
    clear_log; k = cnt; fe_req = 2'b01; tick; fe_req = 0;
    repeat (8) tick;
    check(n == 3 && lc[0] == k + 3, "R4 prefetch latency routine 0", lc[0] - k, 3);
    check(lw[0] == 16'hA000 && lw[2] == 16'hA002, "R4 routine 0 words", lw[2], 16'hA002);
  endtask

  task automatic t_preempt;
    int k;
    clear_log; k = cnt; hs_req = 4'b0010; tick; hs_req = 0;
    while (cnt < k + 4) tick;
    hs_req = 4'b0001; tick; hs_req = 0;
    repeat (30) tick;
    check(n == 12, "R6 preempt count", n, 12);
    check(lw[0] == 16'hA300 && lw[1] == 16'hA301 && lw[2] == 16'hA200, "R6 preempted", lw[2], 16'hA200);
    check(lw[5] == 16'hA203 && lw[6] == 16'hA300 && lw[11] == 16'hA305, "R6 restart from first", lw[6], 16'hA300);
  endtask

  task automatic t_no_preempt_up;
    int k;
    clear_log; k = cnt; hs_req = 4'b0001; tick; hs_req = 0;
    while (cnt < k + 4) tick;
    hs_req = 4'b0100; tick; hs_req = 0;
    repeat (16) tick;
    check(n == 7 && lw[3] == 16'hA203 && lw[4] == 16'hA400, "R6 higher waits", lw[4], 16'hA400);
  endtask

  task automatic t_fe_nonint;
    clear_log; fe_req = 2'b01; tick; fe_req = 0; tick;
    hs_req = 4'b0001; tick; hs_req = 0;
    repeat (16) tick;
    check(n == 7 && lw[2] == 16'hA002 && lw[3] == 16'hA200, "R5 routine 0 completes first", lw[3], 16'hA200);
  endtask

  task automatic t_fe_first;
    clear_log; fe_req = 2'b10; hs_req = 4'b0001; tick; fe_req = 0; hs_req = 0;
    repeat (16) tick;
    check(n == 6 && lw[0] == 16'hA100 && lw[1] == 16'hA101 && lw[2] == 16'hA200, "R7 routine 1 ahead", lw[0], 16'hA100);
  endtask

  task automatic t_wait;
    clear_log; match_n = 1; hs_req = 4'b1000; tick; hs_req = 0;
    repeat (20) tick;
    check(n == 1 && lw[0] == 16'hA500, "R8 stalls without match", n, 1);
    check(int_n == 0, "R11 busy while waiting", int_n, 0);
    match_n = 0; repeat (6) tick;
    check(n == 2 && lw[1] == 16'hA502, "R8 continues on match", lw[1], 16'hA502);
    check(int_n == 1, "R2 internal entry no strobe, done", int_n, 1);
  endtask

  task automatic t_host;
    int an;
    clear_log;
    host_req = 1; host_dq = 16'h5A5A; host_w_n = 1; host_cm_n = 0; host_ec_n = 1;
    tick; check(host_gnt == 1, "R9 grant when idle", host_gnt, 1);
    tick; tick;
    check(n >= 1 && lw[0] == 16'h5A5A && lctl[0] == 3'b101, "R10 host on bus", lw[0], 16'h5A5A);
    fe_req = 2'b01; tick; fe_req = 0;
    repeat (6) tick;
    an = 0;
    for (int i = 0; i < n; i++) if (lw[i][15:12] == 4'hA) an++;
    check(an == 0 && int_n == 1 && host_gnt == 1, "R9 routine waits for host", an, 0);
    host_req = 0; repeat (8) tick;
    an = 0;
    for (int i = 0; i < n; i++) if (lw[i] == 16'hA000) an++;
    check(an == 1 && host_gnt == 0, "R9 routine after host", an, 1);
    hs_req = 4'b0010; tick; hs_req = 0; tick;
    host_req = 1; tick; tick;
    check(host_gnt == 0 && int_n == 0, "R9 no grant while running", host_gnt, 0);
    repeat (10) tick;
    check(host_gnt == 1 && int_n == 1, "R11 grant after routine", host_gnt, 1);
    host_req = 0; repeat (3) tick;
  endtask

  initial begin
    for (int r = 0; r < 6; r++) start_addr[r*6 +: 6] = 6'(r * 8);
    repeat (3) tick;
    t_reset;
    load_prog;
    rst = 0;
    repeat (6) tick;
    t_reset;
    t_run_r2;
    t_run_r0;
    t_preempt;
    t_no_preempt_up;
    t_fe_nonint;
    t_fe_first;
    t_wait;
    t_host;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", cnt, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule